// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit byte address from a core into a physical address by reading two levels of page table from memory. The top ten address bits pick a word in the first-level table. The page that table lives in is given by a root register, which software loads. That word names the page holding the second-level table. The next ten bits pick the word in that table, and it supplies the 20-bit physical page number. The low twelve bits are passed through unchanged as the offset inside a 4096-byte page.

Each table is one page of 1024 one-word entries. A missing table or page ends the walk with a fault code, and so does a write to a page that is not writable. A successful walk marks the final entry as accessed, and also as written when the access is a write. It does so by writing the modified word back, but only when one of those bits was not set before.

The core side is a valid/ready request with a single-cycle response strobe. The memory side is a single request line held until an acknowledge, with a write-enable that selects between a read and a write.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is ready (`req_ready_o`=1), asserts no response and makes no memory request; it never requests memory while ready.
- R2: The first entry read is at byte address {root page, va[31:22], 2'b00} and the second at {first-entry page, va[21:12], 2'b00}. An entry's page number sits in bits 31:12. The address and write-enable are held steady until acknowledged.
- R3: A first-level entry with bit 0 (present) clear ends the walk after exactly one read with fault code 1 and physical address 0.
- R4: A second-level entry with bit 0 clear ends the walk with fault code 2 after two reads and no write.
- R5: On success the response has fault flag 0, code 0 and physical address {entry bits 31:12, va[11:0]}.
- R6: A successful read access writes back the second-level entry with bit 2 (accessed) set and all other bits unchanged.
- R7: A successful write access writes back the second-level entry with bits 2 and 3 (written) set.
- R8: No write-back happens when the marking bits the access needs are already set; at most one write-back happens per walk.
- R9: A write access to a page whose second-level bit 1 (writable) is clear ends with fault code 3 and leaves that entry unwritten.
- R10: A pulse on `root_we_i` loads a new root page used by later walks; while a walk is running `req_ready_o` stays low.
- R11: Every accepted request yields exactly one single-cycle `rsp_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we_i | input | 1 | Load strobe for the root page register |
| root_ppn_i | input | 20 | Page number of the first-level table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_vaddr_i | input | 32 | Byte address to translate |
| req_write_i | input | 1 | Access is a write |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_paddr_o | output | 32 | Translated physical byte address (0 on fault) |
| rsp_fault_o | output | 1 | Walk ended in a fault |
| rsp_cause_o | output | 2 | 0 none, 1 first level absent, 2 page absent, 3 write denied |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Entry byte address |
| mem_wdata_o | output | 32 | Entry value to write back |
| mem_rdata_i | input | 32 | Entry value read, valid with the acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |

## Verification
Addresses are chosen so that both table indices and the offset differ from one case to the next. The two entry addresses then show that the index fields sit at the right places, and the offset shows that it is carried through. Each of the four endings is tried: success, missing table, missing page and denied write. Read and write accesses go first to freshly present entries and then to entries already marked, which separates a needed write-back from a redundant one. A root reload followed by the same address shows that the first read follows the register rather than a fixed table.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_RD,
    ST_L2_RD,
    ST_L2_WB,
    ST_RESP
  } walk_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE         = 2'd0,
    CAUSE_L1_ABSENT    = 2'd1,
    CAUSE_L2_ABSENT    = 2'd2,
    CAUSE_WRITE_DENIED = 2'd3
  } fault_cause_e;

  // Status bit positions inside a table entry
  localparam int PTE_PRESENT  = 0;
  localparam int PTE_WRITABLE = 1;
  localparam int PTE_ACCESSED = 2;
  localparam int PTE_WRITTEN  = 3;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PPN_W = 20,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                   second_level_i,
  input  logic [PPN_W-1:0]       root_ppn_i,
  input  logic [PPN_W-1:0]       table_ppn_i,
  input  logic [IDX_W-1:0]       l1_idx_i,
  input  logic [IDX_W-1:0]       l2_idx_i,
  output logic [PPN_W+OFF_W-1:0] entry_addr_o
);
  localparam int ADDR_W = PPN_W + OFF_W;
  localparam int PAD_W  = OFF_W - IDX_W;

  // Entry byte address: table page, then index, then zero byte-select bits
  function automatic logic [ADDR_W-1:0] entry_address(
    input logic [PPN_W-1:0] tbl,
    input logic [IDX_W-1:0] idx
  );
    return {tbl, idx, {PAD_W{1'b0}}};
  endfunction

  always_comb begin
    if (second_level_i) entry_addr_o = entry_address(table_ppn_i, l2_idx_i);
    else                entry_addr_o = entry_address(root_ppn_i, l1_idx_i);
  end
endmodule

// File: rtl/ptw_pte_update.sv
module ptw_pte_update
  import ptw_pkg::*;
#(
  parameter int PPN_W = 20,
  parameter int OFF_W = 12
) (
  input  logic [PPN_W+OFF_W-1:0] entry_i,
  input  logic                   is_write_i,
  output logic                   present_o,
  output logic [PPN_W-1:0]       ppn_o,
  output logic                   write_denied_o,
  output logic [PPN_W+OFF_W-1:0] updated_o,
  output logic                   needs_wb_o
);
  localparam int W = PPN_W + OFF_W;

  function automatic logic [W-1:0] mark_entry(input logic [W-1:0] e, input logic wr);
    logic [W-1:0] r;
    r = e;
    r[PTE_ACCESSED] = 1'b1;
    if (wr) r[PTE_WRITTEN] = 1'b1;
    return r;
  endfunction

  always_comb begin
    present_o      = entry_i[PTE_PRESENT];
    ppn_o          = entry_i[W-1:OFF_W];
    write_denied_o = is_write_i && !entry_i[PTE_WRITABLE];
    updated_o      = mark_entry(entry_i, is_write_i);
    needs_wb_o     = (updated_o != entry_i);
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int PPN_W = 20,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid_i,
  input  logic [2*IDX_W+OFF_W-1:0]   req_vaddr_i,
  input  logic                       req_write_i,
  output logic                       req_ready_o,
  output logic                       rsp_valid_o,
  output logic [PPN_W+OFF_W-1:0]     rsp_paddr_o,
  output logic                       rsp_fault_o,
  output logic [1:0]                 rsp_cause_o,
  input  logic                       mem_ack_i,
  output logic                       mem_req_o,
  output logic                       mem_we_o,
  output logic [PPN_W+OFF_W-1:0]     mem_wdata_o,
  output logic                       second_level_o,
  output logic [IDX_W-1:0]           l1_idx_o,
  output logic [IDX_W-1:0]           l2_idx_o,
  output logic [PPN_W-1:0]           table_ppn_o,
  output logic                       walk_write_o,
  input  logic                       ent_present_i,
  input  logic [PPN_W-1:0]           ent_ppn_i,
  input  logic                       ent_denied_i,
  input  logic [PPN_W+OFF_W-1:0]     ent_updated_i,
  input  logic                       ent_needs_wb_i
);
  localparam int VA_W   = 2*IDX_W + OFF_W;
  localparam int ADDR_W = PPN_W + OFF_W;

  walk_state_e        state_q;
  fault_cause_e       cause_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [PPN_W-1:0]   tbl_q;
  logic [ADDR_W-1:0]  wb_q;
  logic [ADDR_W-1:0]  paddr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cause_q <= CAUSE_NONE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      tbl_q   <= '0;
      wb_q    <= '0;
      paddr_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q    <= req_vaddr_i;
            wr_q    <= req_write_i;
            cause_q <= CAUSE_NONE;
            paddr_q <= '0;
            state_q <= ST_L1_RD;
          end
        end
        ST_L1_RD: begin
          if (mem_ack_i) begin
            if (!ent_present_i) begin
              cause_q <= CAUSE_L1_ABSENT;
              state_q <= ST_RESP;
            end else begin
              tbl_q   <= ent_ppn_i;
              state_q <= ST_L2_RD;
            end
          end
        end
        ST_L2_RD: begin
          if (mem_ack_i) begin
            if (!ent_present_i) begin
              cause_q <= CAUSE_L2_ABSENT;
              state_q <= ST_RESP;
            end else if (ent_denied_i) begin
              cause_q <= CAUSE_WRITE_DENIED;
              state_q <= ST_RESP;
            end else begin
              paddr_q <= {ent_ppn_i, va_q[OFF_W-1:0]};
              wb_q    <= ent_updated_i;
              state_q <= ent_needs_wb_i ? ST_L2_WB : ST_RESP;
            end
          end
        end
        ST_L2_WB: begin
          if (mem_ack_i) state_q <= ST_RESP;
        end
        ST_RESP:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready_o    = (state_q == ST_IDLE);
    rsp_valid_o    = (state_q == ST_RESP);
    rsp_paddr_o    = paddr_q;
    rsp_cause_o    = cause_q;
    rsp_fault_o    = (cause_q != CAUSE_NONE);
    mem_req_o      = (state_q == ST_L1_RD) || (state_q == ST_L2_RD) || (state_q == ST_L2_WB);
    mem_we_o       = (state_q == ST_L2_WB);
    mem_wdata_o    = wb_q;
    second_level_o = (state_q != ST_L1_RD);
    l1_idx_o       = va_q[VA_W-1 -: IDX_W];
    l2_idx_o       = va_q[OFF_W +: IDX_W];
    table_ppn_o    = tbl_q;
    walk_write_o   = wr_q;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int PPN_W = 20,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     root_we_i,
  input  logic [PPN_W-1:0]         root_ppn_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [2*IDX_W+OFF_W-1:0] req_vaddr_i,
  input  logic                     req_write_i,
  output logic                     rsp_valid_o,
  output logic [PPN_W+OFF_W-1:0]   rsp_paddr_o,
  output logic                     rsp_fault_o,
  output logic [1:0]               rsp_cause_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [PPN_W+OFF_W-1:0]   mem_addr_o,
  output logic [PPN_W+OFF_W-1:0]   mem_wdata_o,
  input  logic [PPN_W+OFF_W-1:0]   mem_rdata_i,
  input  logic                     mem_ack_i
);
  localparam int ADDR_W = PPN_W + OFF_W;

  logic [PPN_W-1:0]  root_q;
  logic              second_level;
  logic [IDX_W-1:0]  l1_idx;
  logic [IDX_W-1:0]  l2_idx;
  logic [PPN_W-1:0]  table_ppn;
  logic              walk_write;
  logic              ent_present;
  logic [PPN_W-1:0]  ent_ppn;
  logic              ent_denied;
  logic [ADDR_W-1:0] ent_updated;
  logic              ent_needs_wb;

  always_ff @(posedge clk) begin
    if (!rst_n)         root_q <= '0;
    else if (root_we_i) root_q <= root_ppn_i;
  end

  ptw_addr_gen #(.PPN_W(PPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) addr_gen_i (
    .second_level_i (second_level),
    .root_ppn_i     (root_q),
    .table_ppn_i    (table_ppn),
    .l1_idx_i       (l1_idx),
    .l2_idx_i       (l2_idx),
    .entry_addr_o   (mem_addr_o)
  );

  ptw_pte_update #(.PPN_W(PPN_W), .OFF_W(OFF_W)) pte_upd_i (
    .entry_i        (mem_rdata_i),
    .is_write_i     (walk_write),
    .present_o      (ent_present),
    .ppn_o          (ent_ppn),
    .write_denied_o (ent_denied),
    .updated_o      (ent_updated),
    .needs_wb_o     (ent_needs_wb)
  );

  ptw_ctrl #(.PPN_W(PPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) ctrl_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid_i),
    .req_vaddr_i    (req_vaddr_i),
    .req_write_i    (req_write_i),
    .req_ready_o    (req_ready_o),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_paddr_o    (rsp_paddr_o),
    .rsp_fault_o    (rsp_fault_o),
    .rsp_cause_o    (rsp_cause_o),
    .mem_ack_i      (mem_ack_i),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_wdata_o    (mem_wdata_o),
    .second_level_o (second_level),
    .l1_idx_o       (l1_idx),
    .l2_idx_o       (l2_idx),
    .table_ppn_o    (table_ppn),
    .walk_write_o   (walk_write),
    .ent_present_i  (ent_present),
    .ent_ppn_i      (ent_ppn),
    .ent_denied_i   (ent_denied),
    .ent_updated_i  (ent_updated),
    .ent_needs_wb_i (ent_needs_wb)
  );
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [OFF_W-1:0]  req_off_i,
  input logic              rsp_valid_o,
  input logic              rsp_fault_o,
  input logic [1:0]        rsp_cause_o,
  input logic [OFF_W-1:0]  rsp_off_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              wb_present_i,
  input logic              wb_accessed_i
);
  logic             busy_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       rd_seen_q;
  logic [1:0]       wr_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      off_q     <= '0;
      rd_seen_q <= '0;
      wr_seen_q <= '0;
    end else if (req_valid_i && req_ready_o) begin
      busy_q    <= 1'b1;
      off_q     <= req_off_i;
      rd_seen_q <= '0;
      wr_seen_q <= '0;
    end else begin
      if (rsp_valid_o) busy_q <= 1'b0;
      if (mem_req_o && mem_ack_i && !mem_we_o && rd_seen_q != 2'd3) rd_seen_q <= rd_seen_q + 2'd1;
      if (mem_req_o && mem_ack_i &&  mem_we_o && wr_seen_q != 2'd3) wr_seen_q <= wr_seen_q + 2'd1;
    end
  end

  assert_idle_no_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !mem_req_o);

  assert_hold_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_l1_fault_one_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_cause_o == 2'd1) |-> (rd_seen_q == 2'd1 && wr_seen_q == 2'd0));

  assert_l2_fault_no_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_cause_o == 2'd2) |-> (rd_seen_q == 2'd2 && wr_seen_q == 2'd0));

  assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_off_i == off_q));

  assert_wb_marks_accessed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (wb_present_i && wb_accessed_i));

  assert_single_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> (wr_seen_q <= 2'd1));

  assert_denied_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_cause_o == 2'd3) |-> (wr_seen_q == 2'd0));

  assert_rsp_in_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> busy_q);

  assert_rsp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

bind ptw_walker ptw_walker_chk #(.OFF_W(OFF_W), .ADDR_W(PPN_W + OFF_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_off_i     (req_vaddr_i[OFF_W-1:0]),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_fault_o   (rsp_fault_o),
  .rsp_cause_o   (rsp_cause_o),
  .rsp_off_i     (rsp_paddr_o[OFF_W-1:0]),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_ack_i     (mem_ack_i),
  .mem_addr_o    (mem_addr_o),
  .wb_present_i  (mem_wdata_o[0]),
  .wb_accessed_i (mem_wdata_o[2])
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_we = 1'b0;
  logic [19:0] root_ppn = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #2.5 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .root_we_i(root_we), .root_ppn_i(root_ppn),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr),
    .rsp_fault_o(rsp_fault), .rsp_cause_o(rsp_cause), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  // Memory model: 16 KiB, acknowledges one cycle after a request
  logic [31:0] mem [0:4095];
  int          rd_cnt = 0, wr_cnt = 0, rsp_cnt = 0, cyc = 0;
  logic [31:0] rd_log [0:15];
  logic [31:0] last_wr_addr = '0, last_wr_data = '0;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt       <= wr_cnt + 1;
        last_wr_addr <= mem_addr;
        last_wr_data <= mem_wdata;
      end else begin
        mem_rdata <= mem[mem_addr[13:2]];
        rd_log[rd_cnt % 16] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end else mem_ack <= 1'b0;
    if (rsp_valid) rsp_cnt <= rsp_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ent_addr(input logic [19:0] ppn, input int idx);
    return ppn * 32'd4096 + idx * 4;
  endfunction

  logic [31:0] w_pa;
  logic        w_flt;
  logic [1:0]  w_cause;
  int          w_rd, w_wr, w_rsp, w_rd0;

  task automatic walk(input logic [31:0] va, input bit wr);
    int wr0, rs0;
    w_rd0 = rd_cnt; wr0 = wr_cnt; rs0 = rsp_cnt;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "ready while walking", {31'd0, req_ready}, 32'd0);
    for (int i = 0; i < 40; i++) begin
      if (rsp_valid) break;
      @(negedge clk);
    end
    w_pa = rsp_paddr; w_flt = rsp_fault; w_cause = rsp_cause;
    repeat (3) @(negedge clk);
    w_rd = rd_cnt - w_rd0; w_wr = wr_cnt - wr0; w_rsp = rsp_cnt - rs0;
    chk("R11", "response pulses", w_rsp, 1);
  endtask

  task automatic t_reset;
    chk("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1", "rsp after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_first_read;
    walk(32'h01407ABC, 1'b0);
    chk("R2", "first entry addr", rd_log[w_rd0 % 16], ent_addr(20'd1, 5));
    chk("R2", "second entry addr", rd_log[(w_rd0 + 1) % 16], ent_addr(20'd2, 7));
    chk("R5", "paddr", w_pa, 32'h12345ABC);
    chk("R5", "fault", {31'd0, w_flt}, 32'd0);
    chk("R5", "cause", {30'd0, w_cause}, 32'd0);
    chk("R6", "writebacks", w_wr, 1);
    chk("R6", "wb addr", last_wr_addr, ent_addr(20'd2, 7));
    chk("R6", "wb data", last_wr_data, 32'h12345003 | 32'h4);
  endtask

  task automatic t_read_marked;
    walk(32'h01407ABC, 1'b0);
    chk("R8", "read on marked entry writebacks", w_wr, 0);
    chk("R8", "paddr", w_pa, 32'h12345ABC);
  endtask

  task automatic t_write;
    walk(32'h01407010, 1'b1);
    chk("R7", "paddr", w_pa, 32'h12345010);
    chk("R7", "writebacks", w_wr, 1);
    chk("R7", "wb data", last_wr_data, 32'h12345003 | 32'h4 | 32'h8);
    walk(32'h01407020, 1'b1);
    chk("R8", "write on marked entry writebacks", w_wr, 0);
    chk("R8", "paddr", w_pa, 32'h12345020);
  endtask

  task automatic t_l1_absent;
    walk(32'h01800123, 1'b0);
    chk("R3", "fault", {31'd0, w_flt}, 32'd1);
    chk("R3", "cause", {30'd0, w_cause}, 32'd1);
    chk("R3", "reads", w_rd, 1);
    chk("R3", "paddr", w_pa, 32'd0);
  endtask

  task automatic t_l2_absent;
    walk(32'h01408456, 1'b1);
    chk("R4", "cause", {30'd0, w_cause}, 32'd2);
    chk("R4", "reads", w_rd, 2);
    chk("R4", "writebacks", w_wr, 0);
    chk("R4", "entry untouched", mem[ent_addr(20'd2, 8) >> 2], 32'h00ABC002);
  endtask

  task automatic t_denied;
    walk(32'h01409FFF, 1'b1);
    chk("R9", "cause", {30'd0, w_cause}, 32'd3);
    chk("R9", "fault", {31'd0, w_flt}, 32'd1);
    chk("R9", "writebacks", w_wr, 0);
    chk("R9", "entry untouched", mem[ent_addr(20'd2, 9) >> 2], 32'h00777001);
    walk(32'h01409FFF, 1'b0);
    chk("R9", "read of readonly page paddr", w_pa, 32'h00777FFF);
    chk("R6", "readonly page wb data", last_wr_data, 32'h00777005);
  endtask

  task automatic t_root;
    @(negedge clk); root_ppn = 20'd3; root_we = 1'b1;
    @(negedge clk); root_we = 1'b0;
    walk(32'h01407ABC, 1'b0);
    chk("R10", "first entry addr after reload", rd_log[w_rd0 % 16], ent_addr(20'd3, 5));
    chk("R10", "paddr after reload", w_pa, 32'h0BEEFABC);
    chk("R6", "wb data after reload", last_wr_data, 32'h0BEEF005);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[ent_addr(20'd1, 5) >> 2] = 32'h00002001;
    mem[ent_addr(20'd2, 7) >> 2] = 32'h12345003;
    mem[ent_addr(20'd2, 8) >> 2] = 32'h00ABC002;
    mem[ent_addr(20'd2, 9) >> 2] = 32'h00777001;
    mem[ent_addr(20'd3, 5) >> 2] = 32'h00003001;
    mem[ent_addr(20'd3, 7) >> 2] = 32'h0BEEF001;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    root_ppn = 20'd1; root_we = 1'b1;
    @(negedge clk); root_we = 1'b0;
    t_first_read();
    t_read_marked();
    t_write();
    t_l1_absent();
    t_l2_absent();
    t_denied();
    t_root();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule